// File: doc/BRIEF.md
# Microstrip Cluster Finder with Pedestal and Common-Mode Correction

The block takes the digitised sample stream of one optical channel that carries two strip readout chips, interleaved word by word, and reduces it to zero-suppressed cluster records. A frame on the input holds `HDR_LEN` header words per chip, followed by one sample per strip for each of the two chips. The two chips take turns on the input: chip A on even words and chip B on odd words. Every strip sample has its own pedestal subtracted, and the result goes into a per-chip frame buffer. While the buffer fills, the block also keeps a running sum of the corrected samples.

Once the whole frame is in, the block works on chip A and then on chip B. For each chip it subtracts the frame's common-mode level, which is the floored mean of that chip's pedestal-subtracted samples. It clips each result to a byte, compares the byte with a global threshold, and merges runs of neighbouring hit strips into clusters. Each cluster goes out as a position record, then a width record, then one record per strip. Each chip ends with an end-of-frame record that carries the cluster count and a header-sync flag.

Both streams use valid/ready handshakes. A record transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the record on the outputs stays exactly as it is. `in_ready` is high only while a frame is being collected, so the producer is held off for the whole processing phase. Pedestals and the threshold are loaded through a plain write port before frames are sent.

Top module: `strip_cluster_finder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Input words alternate between chips, with chip A on even words and chip B on odd words. The first 2*HDR_LEN words of a frame are header words. Strip s of chip c is frame word 2*HDR_LEN + 2*s + c.
- R3: A write with `cfg_thr`=0 stores `cfg_data` as the pedestal at address c*128+s, meaning bit 7 is the chip and bits 6:0 are the strip. That pedestal is subtracted from every later sample of that strip.
- R4: The common-mode level of a chip is the sum of its 128 pedestal-subtracted samples, arithmetically shifted right by 7. It is subtracted from each of those samples.
- R5: A corrected value below 0 is output as 0, and a value above 255 is output as 255. A strip is hit when its clipped byte is strictly greater than the threshold.
- R6: The record kind on `out_kind` is 0 for position, 1 for width, 2 for strip and 3 for end-of-frame. A cluster is sent as a position record (first strip, 0..127), then a width record (1..128), then one strip record per strip in ascending order.
- R7: A cluster that is still open at strip 127 is closed there and sent.
- R8: Each chip's records end with an end-of-frame record whose byte is that chip's cluster count. Chip A is fully sent before chip B, and `out_chip` is 0 for A and 1 for B.
- R9: `out_sync_err` is 1 on a chip's end-of-frame record if any header word of that chip in the frame was below `SYNC_MIN`; otherwise it is 0. It is 0 on all other records.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record holds steady. `in_ready` is 0 from the cycle after the last frame word until after chip B's end-of-frame record, and it is never high together with `out_valid`.
- R11: A write with `cfg_thr`=1 loads `cfg_data[7:0]` as the hit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr | input | 1 | 1: write threshold, 0: write pedestal |
| cfg_addr | input | 8 | Pedestal address {chip, strip} |
| cfg_data | input | 10 | Pedestal value or threshold (low 8 bits) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts input words |
| in_data | input | 10 | Sample or header word |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Sink accepts record |
| out_kind | output | 2 | Record kind (0 pos, 1 width, 2 strip, 3 end) |
| out_chip | output | 1 | Chip the record belongs to |
| out_byte | output | 8 | Record payload |
| out_sync_err | output | 1 | Header sync error, end-of-frame records only |

## Verification
`in_ready` falls on the clock edge that accepts the last frame word. The bench therefore reads it low at the very next falling edge. It reads it high again exactly two falling edges after the edge that carried chip B's end-of-frame record. Record arrival depends on the data, since the scan takes a cycle per strip between clusters. For that reason the bench does not count cycles to predict records; it compares each record at the falling edge before the rising edge on which the record is handshaken. When a record is stalled, the bench compares the outputs at the next falling edge with the values seen at the previous one.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic [1:0] {
    REC_POS   = 2'd0,
    REC_WID   = 2'd1,
    REC_STRIP = 2'd2,
    REC_EOF   = 2'd3
  } rec_kind_t;
endpackage

// File: rtl/scf_ped_store.sv
module scf_ped_store #(
  parameter int W      = 10,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scf_chip_buf.sv
module scf_chip_buf #(
  parameter int VW     = 11,
  parameter int STRIPS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [$clog2(STRIPS)-1:0] wr_idx,
  input  logic signed [VW-1:0] wr_val,
  input  logic [$clog2(STRIPS)-1:0] rd_idx,
  output logic signed [VW-1:0] rd_val,
  output logic signed [VW-1:0] cm
);
  localparam int SIDX_W = $clog2(STRIPS);
  localparam int SUM_W  = VW + SIDX_W;

  logic signed [VW-1:0]    mem [STRIPS];
  logic signed [SUM_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum <= '0;
    else if (wr_en)    sum <= sum + SUM_W'(wr_val);
  end

  assign rd_val = mem[rd_idx];
  // floored mean: upper bits of the sum are the arithmetic shift by SIDX_W
  assign cm     = sum[SUM_W-1:SIDX_W];
endmodule

// File: rtl/scf_cluster_scan.sv
module scf_cluster_scan
  import scf_pkg::*;
#(
  parameter int VW     = 11,
  parameter int STRIPS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 chip,
  input  logic signed [VW-1:0] cm,
  input  logic [7:0]           thr,
  input  logic                 sync_err,
  output logic [$clog2(STRIPS)-1:0] rd_idx,
  input  logic signed [VW-1:0] rd_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic                 out_chip,
  output logic [7:0]           out_byte,
  output logic                 out_sync_err,
  output logic                 done
);
  localparam int SIDX_W = $clog2(STRIPS);
  localparam int CW_W   = SIDX_W + 1;
  localparam logic [SIDX_W-1:0] LAST = SIDX_W'(STRIPS - 1);
  localparam logic signed [VW:0] MAXB = (VW+1)'(255);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_POS, S_WID, S_STRIP, S_EOF} st_t;
  st_t st;

  logic [SIDX_W-1:0] idx, cstart, ei;
  logic [CW_W-1:0]   cwid, ecnt;
  logic              open_q, fin, chip_q;
  logic [7:0]        ccount;
  logic signed [VW:0] corr;
  logic [7:0]        clip;
  logic              hit, last, hs;

  assign rd_idx = (st == S_STRIP) ? ei : idx;
  assign corr   = $signed({rd_val[VW-1], rd_val}) - $signed({cm[VW-1], cm});

  always_comb begin
    if (corr[VW])         clip = 8'd0;
    else if (corr > MAXB) clip = 8'hFF;
    else                  clip = corr[7:0];
  end

  assign hit  = clip > thr;
  assign last = (idx == LAST);

  assign out_valid = (st == S_POS) || (st == S_WID) || (st == S_STRIP) || (st == S_EOF);
  assign hs        = out_valid && out_ready;
  assign out_chip  = chip_q;
  assign out_sync_err = (st == S_EOF) && sync_err;

  always_comb begin
    unique case (st)
      S_POS:   begin out_kind = REC_POS;   out_byte = 8'(cstart); end
      S_WID:   begin out_kind = REC_WID;   out_byte = 8'(cwid);   end
      S_STRIP: begin out_kind = REC_STRIP; out_byte = clip;       end
      S_EOF:   begin out_kind = REC_EOF;   out_byte = ccount;     end
      default: begin out_kind = REC_POS;   out_byte = 8'd0;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cstart <= '0; ei <= '0; cwid <= '0; ecnt <= '0;
      open_q <= 1'b0; fin <= 1'b0; chip_q <= 1'b0; ccount <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_SCAN; idx <= '0; open_q <= 1'b0; fin <= 1'b0;
          ccount <= '0; chip_q <= chip;
        end
        S_SCAN: begin
          if (hit) begin
            if (!open_q) begin cstart <= idx; cwid <= CW_W'(1); open_q <= 1'b1; end
            else cwid <= cwid + 1'b1;
            if (last) begin open_q <= 1'b0; fin <= 1'b1; st <= S_POS; end
            else idx <= idx + 1'b1;
          end else if (open_q) begin
            open_q <= 1'b0; fin <= last; st <= S_POS; idx <= idx + 1'b1;
          end else if (last) begin
            st <= S_EOF;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_POS: if (hs) begin st <= S_WID; ccount <= ccount + 1'b1; end
        S_WID: if (hs) begin st <= S_STRIP; ei <= cstart; ecnt <= cwid; end
        S_STRIP: if (hs) begin
          ei <= ei + 1'b1; ecnt <= ecnt - 1'b1;
          if (ecnt == CW_W'(1)) st <= fin ? S_EOF : S_SCAN;
        end
        S_EOF: if (hs) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import scf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int STRIPS   = 128,
  parameter int HDR_LEN  = 3,
  parameter int SYNC_MIN = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_thr,
  input  logic [7:0]          cfg_addr,
  input  logic [SAMPLE_W-1:0] cfg_data,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_kind,
  output logic                out_chip,
  output logic [7:0]          out_byte,
  output logic                out_sync_err
);
  localparam int SIDX_W = $clog2(STRIPS);
  localparam int PA_W   = SIDX_W + 1;
  localparam int VW     = SAMPLE_W + 1;
  localparam int HC_W   = $clog2(HDR_LEN + 1);
  localparam logic [SIDX_W-1:0] LAST = SIDX_W'(STRIPS - 1);

  typedef enum logic [1:0] {T_FILL, T_RUN_A, T_RUN_B} top_st_t;
  top_st_t st;

  logic              tog, in_hdr, start, done, clr;
  logic [HC_W-1:0]   hcnt;
  logic [SIDX_W-1:0] sidx, rd_idx;
  logic [1:0]        sync_bad;
  logic [7:0]        thr_q;
  logic              acc;
  logic [SAMPLE_W-1:0] ped;
  logic signed [VW-1:0] diff;
  logic signed [VW-1:0] buf_rd [2];
  logic signed [VW-1:0] buf_cm [2];
  logic              run_chip;

  assign in_ready = (st == T_FILL);
  assign acc      = in_valid && in_ready;
  assign run_chip = (st == T_RUN_B);

  scf_ped_store #(.W(SAMPLE_W), .ADDR_W(PA_W)) u_ped (
    .clk(clk), .we(cfg_we && !cfg_thr), .waddr(cfg_addr[PA_W-1:0]), .wdata(cfg_data),
    .raddr({tog, sidx}), .rdata(ped)
  );

  assign diff = $signed({1'b0, in_data}) - $signed({1'b0, ped});

  for (genvar c = 0; c < 2; c++) begin : g_chip
    scf_chip_buf #(.VW(VW), .STRIPS(STRIPS)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(acc && !in_hdr && (tog == 1'(c))),
      .wr_idx(sidx), .wr_val(diff),
      .rd_idx(rd_idx), .rd_val(buf_rd[c]), .cm(buf_cm[c])
    );
  end

  scf_cluster_scan #(.VW(VW), .STRIPS(STRIPS)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .chip(run_chip),
    .cm(buf_cm[run_chip]), .thr(thr_q), .sync_err(sync_bad[run_chip]),
    .rd_idx(rd_idx), .rd_val(buf_rd[run_chip]),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_chip(out_chip), .out_byte(out_byte), .out_sync_err(out_sync_err),
    .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 thr_q <= 8'd0;
    else if (cfg_we && cfg_thr) thr_q <= cfg_data[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_FILL; tog <= 1'b0; in_hdr <= 1'b1; hcnt <= '0; sidx <= '0;
      start <= 1'b0; clr <= 1'b0; sync_bad <= 2'b00;
    end else begin
      start <= 1'b0;
      clr   <= 1'b0;
      if (clr) sync_bad <= 2'b00;
      unique case (st)
        T_FILL: if (acc) begin
          tog <= ~tog;
          if (in_hdr && (in_data < SAMPLE_W'(SYNC_MIN))) sync_bad[tog] <= 1'b1;
          if (tog) begin
            if (in_hdr) begin
              if (hcnt == HC_W'(HDR_LEN - 1)) in_hdr <= 1'b0;
              else hcnt <= hcnt + 1'b1;
            end else if (sidx == LAST) begin
              sidx <= '0; in_hdr <= 1'b1; hcnt <= '0;
              st <= T_RUN_A; start <= 1'b1;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
        end
        T_RUN_A: if (done) begin st <= T_RUN_B; start <= 1'b1; end
        T_RUN_B: if (done) begin st <= T_FILL; clr <= 1'b1; end
        default: st <= T_FILL;
      endcase
    end
  end
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int STRIPS = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_kind,
  input logic       out_chip,
  input logic [7:0] out_byte
);
  // R10
  io_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_kind) && $stable(out_chip)));

  // R6
  pos_then_wid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'd0) |=> (out_valid && out_kind == 2'd1));

  // R6
  wid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1) |-> (out_byte != 8'd0 && 32'(out_byte) <= STRIPS));

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |-> (32'(out_byte) < STRIPS));

  // R8
  chip_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'd3 && !out_chip) |=> !in_ready);
endmodule

bind strip_cluster_finder scf_checker #(.STRIPS(STRIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_chip(out_chip), .out_byte(out_byte)
);

// File: tb/strip_cluster_finder_test.sv
module strip_cluster_finder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 128;
  localparam int HDR = 3;
  localparam int NV  = 6;
  // thr[47:40] period[39:32] width[31:24] offset[23:16] amplitude[15:6] badhdr[5:4]
  localparam logic [47:0] VEC [NV] = '{
    {8'd40,  8'd16,  8'd3,  8'd2, 10'd150, 2'b00, 4'd0},
    {8'd40,  8'd32,  8'd1,  8'd0, 10'd700, 2'b10, 4'd0},
    {8'd255, 8'd8,   8'd2,  8'd0, 10'd100, 2'b01, 4'd0},
    {8'd20,  8'd64,  8'd20, 8'd0, 10'd200, 2'b00, 4'd0},
    {8'd60,  8'd5,   8'd2,  8'd1, 10'd180, 2'b00, 4'd0},
    {8'd50,  8'd127, 8'd1,  8'd0, 10'd400, 2'b11, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_thr = 0;
  logic [7:0] cfg_addr = 0;
  logic [9:0] cfg_data = 0;
  logic in_valid = 0, in_ready;
  logic [9:0] in_data = 0;
  logic out_valid, out_ready = 0, out_chip, out_sync_err;
  logic [1:0] out_kind;
  logic [7:0] out_byte;

  int checks = 0, errors = 0;
  int ped [2][NS];
  int smp [2][NS];
  int exp_rec [1024];
  int n_exp;

  strip_cluster_finder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_chip(out_chip),
    .out_byte(out_byte), .out_sync_err(out_sync_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    report();
    $finish;
  end

  function automatic int pack_rec(int kind, int chip, int flag, int b);
    return (kind << 10) | (chip << 9) | (flag << 8) | b;
  endfunction

  // reference model: record list for one frame
  task automatic build(int sc, int thr, int per, int cw, int off, int amp, int bad);
    n_exp = 0;
    for (int c = 0; c < 2; c++) begin
      int sum = 0, cm, cnt = 0, s = 0;
      int corr [NS];
      for (int k = 0; k < NS; k++) begin
        ped[c][k] = (k*37 + c*91 + sc*13) % 200;
        smp[c][k] = ped[c][k] + (k*7 + c*3 + sc) % 16 + ((((k + off + 5*c) % per) < cw) ? amp : 0);
        sum += smp[c][k] - ped[c][k];
      end
      cm = sum >>> 7;
      for (int k = 0; k < NS; k++) begin
        int v = smp[c][k] - ped[c][k] - cm;
        corr[k] = (v < 0) ? 0 : (v > 255) ? 255 : v;
      end
      while (s < NS) begin
        if (corr[s] > thr) begin
          int e = s;
          while (e + 1 < NS && corr[e+1] > thr) e++;
          exp_rec[n_exp++] = pack_rec(0, c, 0, s);
          exp_rec[n_exp++] = pack_rec(1, c, 0, e - s + 1);
          for (int k = s; k <= e; k++) exp_rec[n_exp++] = pack_rec(2, c, 0, corr[k]);
          cnt++;
          s = e + 1;
        end else s++;
      end
      exp_rec[n_exp++] = pack_rec(3, c, (bad >> c) & 1, cnt);
    end
  endtask

  task automatic cfg_write(logic t, int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_thr = t; cfg_addr = 8'(a); cfg_data = 10'(d);
  endtask

  task automatic put(int v);
    do begin
      @(negedge clk);
      in_valid = 1; in_data = 10'(v);
    end while (!in_ready);
  endtask

  task automatic send(int bad);
    for (int k = 0; k < 2*HDR; k++) put((((bad >> (k % 2)) & 1) != 0) ? 100 : 1000);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 2; c++) put(smp[c][s]);
    @(negedge clk);
    in_valid = 0;
    chk("R10", int'(in_ready), 0, "in_ready during processing");
  endtask

  task automatic drain(int sc);
    int got = 0, cyc = 0, act;
    bit pv = 0;
    int pvals = 0;
    string req;
    while (got < n_exp) begin
      @(negedge clk);
      cyc++;
      act = pack_rec(int'(out_kind), int'(out_chip), int'(out_sync_err), int'(out_byte));
      if (pv) chk("R10", out_valid ? act : -1, pvals, "record held under stall");
      out_ready = ((cyc + sc) % 4) != 3;
      pv = out_valid && !out_ready;
      pvals = act;
      if (out_valid && out_ready) begin
        case (exp_rec[got] >> 10)
          0: req = "R2 R6 R7";
          1: req = "R6";
          2: req = "R3 R4 R5";
          default: req = "R8 R9 R11";
        endcase
        chk(req, act, exp_rec[got], $sformatf("frame %0d record %0d", sc, got));
        got++;
      end
    end
    repeat (2) @(negedge clk);
    out_ready = 0;
    chk("R10", int'(in_ready), 1, "in_ready after last end-of-frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(in_ready), 1, "in_ready after reset");
    chk("R1", int'(out_valid), 0, "out_valid after reset");

    for (int v = 0; v < NV; v++) begin
      int thr = int'(VEC[v][47:40]), per = int'(VEC[v][39:32]), cw = int'(VEC[v][31:24]);
      int off = int'(VEC[v][23:16]), amp = int'(VEC[v][15:6]), bad = int'(VEC[v][5:4]);
      build(v, thr, per, cw, off, amp, bad);
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < NS; s++) cfg_write(0, c*NS + s, ped[c][s]);
      cfg_write(1, 0, thr); // R11 threshold load
      @(negedge clk);
      cfg_we = 0;
      send(bad);
      drain(v);
    end

    report();
    $finish;
  end
endmodule